// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a two-wire serial bus and decides whether the node it belongs to is being addressed. After a START or repeated START it shifts in the first byte, most significant bit first. It treats the upper seven bits as the address and the lowest bit as the transfer direction. It then compares the address with a programmed own address. A per-bit mask can leave any address bit out of that compare. An enable bit adds recognition of the all-zero general-call address.

When a compare succeeds, a sticky event flag is raised and the direction bit is latched. A status bit records whether the hit came from the general-call address. Software clears the flag with a single-cycle clear pulse. An interrupt request is driven only while the flag is set and both a local enable and a global enable are high. Driving the acknowledge, handling data bytes, stretching the clock and acting as master are left to other logic.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, both register readbacks are zero, and `evt_flag`, `irq`, `gcall_hit` and `rw_dir` are all zero.
- R2: A write through `own_wr` stores all eight bits of `wdata`. Bits 7..1 hold the own address and bit 0 enables general-call recognition. A write through `mask_wr` stores `wdata[7:1]` only, and bit 0 of `mask_rd` always reads zero.
- R3: SCL and SDA each pass through a two-flop synchronizer. START is SDA falling while SCL is high. Data bits are taken on SCL rising edges, MSB first. On a match, `evt_flag` goes high on the fourth clock edge after the eighth SCL rise at the pins, and not earlier.
- R4: A mask bit of one at `mask_rd[k]` (k = 7..1) excludes received address bit k-1 from the own-address compare. Unmasked bits must be equal.
- R5: If `own_rd[0]` is one, a received address of 0x00 is a match and sets `gcall_hit`. This compare uses all seven bits whatever the mask holds. If `own_rd[0]` is zero, no general-call status is ever reported.
- R6: On a match, `rw_dir` takes bit 0 of the received byte.
- R7: `evt_flag` stays set until a `flag_clr` pulse. While it is set, `gcall_hit` and `rw_dir` keep their values, and a compare that completes is discarded. This includes a compare that completes in the same cycle as the clear.
- R8: `irq` is `evt_flag` AND `irq_en` AND `glob_irq_en`. The flag is still set when `irq_en` is zero.
- R9: A STOP (SDA rising while SCL is high), or a START arriving before eight bits, aborts the byte without setting the flag. After a repeated START, counting restarts from the first bit.
- R10: An address that matches neither the own address nor the general call leaves the flag clear.
- R11: Once the eighth bit is taken, further SCL rises are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| own_wr | input | 1 | Write strobe for the own-address register |
| mask_wr | input | 1 | Write strobe for the mask register |
| wdata | input | 8 | Register write data |
| own_rd | output | 8 | Own-address register readback |
| mask_rd | output | 8 | Mask register readback, bit 0 zero |
| flag_clr | input | 1 | Write-one-to-clear pulse for the event flag |
| irq_en | input | 1 | Local interrupt enable |
| glob_irq_en | input | 1 | Global interrupt enable |
| evt_flag | output | 1 | Sticky address-match flag |
| gcall_hit | output | 1 | Last accepted match was the general call |
| rw_dir | output | 1 | Direction bit latched on the last accepted match |
| irq | output | 1 | Gated interrupt request |

## Verification
A match result (flag, general-call status and direction) is due on the fourth clock edge after the eighth SCL rise at the pins. That count is two synchronizer edges, one edge to capture the bit and one edge to load the flag. The interrupt output follows the flag and enables with no added delay. Register readbacks follow a write by one edge. The bench changes inputs on falling clock edges and counts exactly that many rising edges before it samples. In one case it also checks that the flag is still clear one edge earlier. Abort and ignore cases are sampled well after the point at which a wrongly counted byte would have raised the flag.

// File: rtl/i2c_ad_pkg.sv
// Package: shared widths for the address recognizer.
// Assumes a standard 7-bit address followed by one direction bit.
package i2c_ad_pkg;
    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = ADDR_W + 1;
    localparam int SYNC_N  = 2;
endpackage

// File: rtl/i2c_ad_sync.sv
// Module: bus line synchronizer and condition detector.
// Brings SCL/SDA into the clock domain through SYNC_N flops, keeps one
// extra history stage, and flags SCL rising, START and STOP.
// Assumes the idle bus is high; reset loads ones so no false event appears.
module i2c_ad_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_N-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;
    logic              scl_s;

    // Synchronizer chains, one per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[SYNC_N-1];
    assign sda_s = sda_ff[SYNC_N-1];

    // History stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Conditions: SDA moving while SCL stays high.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_ad_shift.sv
// Module: first-byte shifter.
// Arms on START, shifts BYTE_W bits MSB first on SCL rises, then pulses
// byte_valid for one cycle and disarms until the next START.
// Assumes START/STOP never coincide with an SCL rise (protocol guarantee).
module i2c_ad_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_valid
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    // Bit counter, arming and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            cnt        <= '0;
            byte_q     <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (start_ev) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (stop_ev) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (scl_rise && armed) begin
                byte_q <= {byte_q[BYTE_W-2:0], sda_s};
                if (cnt == LAST) begin
                    cnt        <= '0;
                    armed      <= 1'b0;
                    byte_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9: any START or STOP leaves the counter at bit zero.
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> (cnt == '0));
    // R3: the counter never runs past the last bit.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R11: a completed byte is reported once, then the shifter is idle.
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !armed);
endmodule

// File: rtl/i2c_ad_cmp.sv
// Module: masked address comparator.
// One comparator per address bit, each bypassed by its mask bit; the
// general-call test is separate and never masked.
// Purely combinational; the caller samples on byte_valid.
module i2c_ad_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic              gc_en,
    output logic              own_hit,
    output logic              gc_hit
);
    logic [ADDR_W-1:0] bit_ok;

    // Per-bit compare with mask bypass.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(rx_addr[i] ^ own_addr[i]);
    end

    // Reduce bit results; general call checks all bits unmasked.
    always_comb begin
        own_hit = &bit_ok;
        gc_hit  = gc_en & (rx_addr == '0);
    end
endmodule

// File: rtl/i2c_addr_detect.sv
// Module: I2C slave address recognizer (top).
// Holds the own-address and mask registers, joins synchronizer, shifter
// and comparator, and keeps the sticky event flag with its status bits.
// Assumes flag_clr is a single-cycle pulse from a register write.
module i2c_addr_detect #(
    parameter int ADDR_W = i2c_ad_pkg::ADDR_W,
    parameter int SYNC_N = i2c_ad_pkg::SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              own_wr,
    input  logic              mask_wr,
    input  logic [ADDR_W:0]   wdata,
    output logic [ADDR_W:0]   own_rd,
    output logic [ADDR_W:0]   mask_rd,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              glob_irq_en,
    output logic              evt_flag,
    output logic              gcall_hit,
    output logic              rw_dir,
    output logic              irq
);
    localparam int REG_W = ADDR_W + 1;

    logic [REG_W-1:0]  own_q;
    logic [ADDR_W-1:0] mask_q;
    logic              sda_s, scl_rise, start_ev, stop_ev;
    logic [REG_W-1:0]  byte_q;
    logic              byte_valid;
    logic              own_hit, gc_hit;
    logic              load;

    // Register file: own address plus enable, and the 7-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= '0;
            mask_q <= '0;
        end else begin
            if (own_wr)  own_q  <= wdata;
            if (mask_wr) mask_q <= wdata[REG_W-1:1];
        end
    end

    assign own_rd  = own_q;
    assign mask_rd = {mask_q, 1'b0};

    i2c_ad_sync #(.SYNC_N(SYNC_N)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_ad_shift #(.BYTE_W(REG_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .byte_q     (byte_q),
        .byte_valid (byte_valid)
    );

    i2c_ad_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .rx_addr  (byte_q[REG_W-1:1]),
        .own_addr (own_q[REG_W-1:1]),
        .mask     (mask_q),
        .gc_en    (own_q[0]),
        .own_hit  (own_hit),
        .gc_hit   (gc_hit)
    );

    // Accept a compare result only while the flag is clear.
    assign load = byte_valid & (own_hit | gc_hit) & ~evt_flag;

    // Sticky flag with latched status; clear pulse drops the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_flag  <= 1'b0;
            gcall_hit <= 1'b0;
            rw_dir    <= 1'b0;
        end else if (load) begin
            evt_flag  <= 1'b1;
            gcall_hit <= gc_hit;
            rw_dir    <= byte_q[0];
        end else if (flag_clr) begin
            evt_flag  <= 1'b0;
        end
    end

    // Interrupt gating by local and global enables.
    assign irq = evt_flag & irq_en & glob_irq_en;

    // R7: flag holds until cleared.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !flag_clr) |=> evt_flag);
    // R7: a clear pulse on a set flag drops it.
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && flag_clr) |=> !evt_flag);
    // R7: status bits do not move while the flag is set.
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag |=> ($stable(gcall_hit) && $stable(rw_dir)));
    // R3: the flag only rises after a completed byte.
    p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> $past(byte_valid));
    // R5: general-call status requires an all-zero address and the enable.
    p_gc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_flag) && gcall_hit) |-> ($past(byte_q[REG_W-1:1]) == '0 && $past(own_q[0])));
endmodule

// File: tb/i2c_addr_detect_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_detect_tb_top;
    typedef struct {
        logic  flag;
        logic  irq;
        logic  gc;
        logic  rw;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       own_wr = 1'b0, mask_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] own_rd, mask_rd;
    logic       flag_clr = 1'b0, irq_en = 1'b0, glob_irq_en = 1'b0;
    logic       evt_flag, gcall_hit, rw_dir, irq;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];
    event chk_ev;
    bit   done = 1'b0;

    localparam int HALF = 6;

    always #2.5 clk = ~clk;

    i2c_addr_detect dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .own_wr(own_wr), .mask_wr(mask_wr), .wdata(wdata),
        .own_rd(own_rd), .mask_rd(mask_rd), .flag_clr(flag_clr),
        .irq_en(irq_en), .glob_irq_en(glob_irq_en),
        .evt_flag(evt_flag), .gcall_hit(gcall_hit), .rw_dir(rw_dir), .irq(irq)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue an expectation, wake the monitor.
    task automatic expect_st(input logic f, input logic i, input logic g, input logic r, input string tag);
        exp_t e;
        e.flag = f; e.irq = i; e.gc = g; e.rw = r; e.tag = tag;
        sb_q.push_back(e);
        ->chk_ev;
        #2;
    endtask

    // Monitor: pops one expectation per event and compares the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if ({evt_flag, irq, gcall_hit, rw_dir} !== {e.flag, e.irq, e.gc, e.rw}) begin
                    n_fails++;
                    $display("FAIL %s: got flag/irq/gc/rw %b%b%b%b expected %b%b%b%b", e.tag,
                             evt_flag, irq, gcall_hit, rw_dir, e.flag, e.irq, e.gc, e.rw);
                end
            end
        end
    end

    task automatic wr_own(input logic [7:0] d);
        @(negedge clk); own_wr = 1'b1; wdata = d;
        @(negedge clk); own_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] d);
        @(negedge clk); mask_wr = 1'b1; wdata = d;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        wait_n(2);
    endtask

    // START or repeated START from any line state.
    task automatic bus_start();
        sda = 1'b1; wait_n(HALF);
        scl = 1'b1; wait_n(HALF);
        sda = 1'b0; wait_n(HALF);
        scl = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    wait_n(HALF);
        scl = 1'b1; wait_n(HALF);
        scl = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_n(HALF);
        scl = 1'b1; wait_n(HALF);
        sda = 1'b1; wait_n(HALF);
    endtask

    // START plus a full byte; returns four edges after the last SCL rise,
    // with SCL still high. lat_chk checks the flag is still clear one edge earlier.
    task automatic send_addr(input logic [7:0] b, input bit lat_chk);
        bus_start();
        for (int k = 7; k >= 1; k--) bus_bit(b[k]);
        sda = b[0]; wait_n(HALF);
        scl = 1'b1;
        if (lat_chk) begin
            wait_n(3);
            n_checks++;
            if (evt_flag !== 1'b0) begin
                n_fails++;
                $display("FAIL R3 latency: got flag %b expected 0 at edge 3", evt_flag);
            end
            wait_n(1);
        end else begin
            wait_n(4);
        end
    endtask

    task automatic finish_byte();
        wait_n(HALF);
        scl = 1'b0; wait_n(HALF);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset state
        chk8(own_rd, 8'h00, "R1 own reset");
        chk8(mask_rd, 8'h00, "R1 mask reset");
        expect_st(0, 0, 0, 0, "R1 outputs reset");

        // R2: register readback, reserved mask bit
        wr_mask(8'hFF);
        wait_n(1);
        chk8(mask_rd, 8'hFE, "R2 mask bit0 zero");
        wr_own(8'h55);
        wait_n(1);
        chk8(own_rd, 8'h55, "R2 own readback");
        wr_mask(8'h00);

        // R3/R6/R8: own address 0x2A, gc off, read direction, local enable off
        wr_own(8'h54);
        glob_irq_en = 1'b1;
        send_addr(8'h55, 1'b1);
        expect_st(1, 0, 0, 1, "R3 R6 R8 own match flag with irq_en low");
        finish_byte();
        bus_stop();

        // R8: interrupt gating
        irq_en = 1'b1; wait_n(1);
        expect_st(1, 1, 0, 1, "R8 both enables");
        glob_irq_en = 1'b0; wait_n(1);
        expect_st(1, 0, 0, 1, "R8 global off");
        glob_irq_en = 1'b1;

        // R7: flag set, a general call does not reload status
        wr_own(8'h55);
        send_addr(8'h00, 1'b0);
        finish_byte();
        bus_stop();
        expect_st(1, 1, 0, 1, "R7 status held while set");
        clear_flag();
        expect_st(0, 0, 0, 1, "R7 clear pulse");

        // R5: general call enabled
        send_addr(8'h00, 1'b0);
        expect_st(1, 1, 1, 0, "R5 general call hit");
        finish_byte();
        bus_stop();
        clear_flag();

        // R4: mask ignores address bits 1..0
        wr_own(8'h54);
        wr_mask(8'h06);
        send_addr(8'h52, 1'b0);
        expect_st(1, 1, 0, 0, "R4 masked match");
        finish_byte();
        bus_stop();
        clear_flag();
        send_addr(8'h5C, 1'b0);
        expect_st(0, 0, 0, 0, "R4 R10 unmasked bit differs");
        finish_byte();
        bus_stop();

        // R5: general call never masked
        wr_own(8'h55);
        wr_mask(8'h02);
        send_addr(8'h02, 1'b0);
        expect_st(0, 0, 0, 0, "R5 general call not masked");
        finish_byte();
        bus_stop();

        // R5: general call disabled, all-ones mask gives own match without gc status
        wr_own(8'h54);
        wr_mask(8'hFE);
        send_addr(8'h00, 1'b0);
        expect_st(1, 1, 0, 0, "R5 gc disabled own match only");
        finish_byte();
        bus_stop();
        clear_flag();

        // R5/R10: gc disabled, no mask, zero address
        wr_mask(8'h00);
        send_addr(8'h00, 1'b0);
        expect_st(0, 0, 0, 0, "R5 R10 gc disabled no match");
        finish_byte();
        bus_stop();

        // R9: STOP mid-byte aborts
        bus_start();
        bus_bit(0); bus_bit(1); bus_bit(0); bus_bit(1);
        bus_stop();
        wait_n(10);
        expect_st(0, 0, 0, 0, "R9 stop abort");

        // R9: repeated START mid-byte restarts the count
        bus_start();
        bus_bit(0); bus_bit(1); bus_bit(0); bus_bit(1);
        send_addr(8'h55, 1'b0);
        expect_st(1, 1, 0, 1, "R9 repeated start realign");
        finish_byte();
        bus_bit(0);
        clear_flag();

        // R11: bits after the first byte are ignored
        for (int k = 7; k >= 0; k--) bus_bit(k[0] ? 1'b0 : 1'b1);
        wait_n(10);
        expect_st(0, 0, 0, 1, "R11 later byte ignored");
        bus_stop();

        wait_n(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule